// File: doc/BRIEF.md
# ADC Trigger-to-Command Dispatcher

This block sits in front of an analog-to-digital converter and decides what the converter does next. Sixteen trigger sources, indexed 0 to 15, each own one control entry. Each source can request a conversion in one of two ways. The first is a rising edge on its hardware trigger pin, which counts only when the entry's hardware-enable bit is set. The second is a write to the software trigger register. Each entry also holds a command selector. The selector picks one of fifteen stored command descriptors. Each descriptor is two 32-bit words that tell the converter which channel to sample, at what resolution and for how long.

Requests wait in a pending vector. A two-state machine hands them to the converter over a valid/ready handshake. In `ST_IDLE` the machine looks at the lowest-numbered pending entry and always clears that entry's pending bit. If the entry's selector is nonzero, it takes the grant transition to `ST_ISSUE` and captures the entry index, the selector and both descriptor words. If the selector is 0, it takes the drop transition: the request is discarded and the machine stays in `ST_IDLE`. In `ST_ISSUE` it holds the start request until the converter accepts it. The accept transition then returns the machine to `ST_IDLE`.

Top module: `adc_trig_dispatch`

## Requirements
- R1: After reset `conv_valid` is 0, every entry has hardware enable 0 and selector 0, and a software request on an entry that has not been configured produces no conversion.
- R2: A write to address i (0 to 15) sets entry i: bit 0 is the hardware enable and bits 7:4 are the command selector.
- R3: Command k (1 to 15) is stored at address 16+2(k-1) for the low word and 16+2(k-1)+1 for the high word. The start request carries both words of the selected command on `conv_desc_lo`/`conv_desc_hi`.
- R4: Writing address 46 with bit i set requests one conversion through entry i, with `conv_valid` high after the second rising edge that counts from the write edge. The request clears itself, so one write yields exactly one conversion.
- R5: With hardware enable set, a rising level on `trig_in[i]` passes a two-flop synchronizer and an edge detector. `conv_valid` is then high after the fourth rising clock edge following the input change, carrying `conv_src` = i and the entry's selector.
- R6: With hardware enable 0, the entry's trigger input has no effect, but software requests on that entry still start its command.
- R7: A trigger input held high starts only one conversion.
- R8: When several entries are pending, the lowest index is issued first. The others stay pending and are issued, in index order, after each accept.
- R9: A request on an entry whose selector is 0 is discarded and produces no start. Other pending entries are still served afterwards.
- R10: While `conv_valid` is high and `conv_ready` is low, the source, command and descriptor outputs stay stable. After an accept, `conv_valid` is low for at least the following cycle.
- R11: A new request on an entry arriving in the same cycle that the entry's pending request is granted is kept, and it produces a further conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| trig_in | input | 16 | Asynchronous hardware trigger inputs, one per entry |
| conv_valid | output | 1 | Conversion start request |
| conv_ready | input | 1 | Converter accepts the start request |
| conv_src | output | 4 | Index of the entry that fired |
| conv_cmd | output | 4 | Selected command number (1 to 15) |
| conv_desc_lo | output | 32 | Descriptor low word of the selected command |
| conv_desc_hi | output | 32 | Descriptor high word of the selected command |

## Verification
Two things can land in the same clock edge: the grant that consumes an entry's pending bit, and a fresh software request that sets the same bit. The bench provokes this by holding a software trigger write for entry 1 across two consecutive edges, so the second write meets the grant of the first. It passes only if exactly two starts for entry 1 come out, and no third. A second overlap, between a discarded selector-0 request and a valid request pending in the same cycle, is judged by whether the valid request is issued right after the drop.

// File: rtl/adc_disp_pkg.sv
package adc_disp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } disp_state_e;

    // Field placement inside a trigger entry write
    localparam int ENT_EN_BIT  = 0;
    localparam int ENT_SEL_LSB = 4;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= trig_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import adc_disp_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_CMD = 15,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [SEL_W-1:0]              rd_sel,
    output logic [NUM_SRC-1:0]            hw_en,
    output logic [NUM_SRC-1:0][SEL_W-1:0] sel,
    output logic [NUM_SRC-1:0]            sw_req,
    output logic [DATA_W-1:0]             rd_lo,
    output logic [DATA_W-1:0]             rd_hi
);
    localparam int CMD_BASE = NUM_SRC;
    localparam logic [ADDR_W-1:0] SW_ADDR = ADDR_W'(NUM_SRC + 2 * NUM_CMD);

    logic [DATA_W-1:0] lo_q [NUM_CMD];
    logic [DATA_W-1:0] hi_q [NUM_CMD];

    // Trigger entries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_en <= '0;
            sel   <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    hw_en[i] <= wr_data[ENT_EN_BIT];
                    sel[i]   <= wr_data[ENT_SEL_LSB +: SEL_W];
                end
            end
        end
    end

    // Command descriptor table, one pair of words per command
    generate
        for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo_q[k] <= '0;
                    hi_q[k] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == ADDR_W'(CMD_BASE + 2 * k))
                        lo_q[k] <= wr_data;
                    if (wr_addr == ADDR_W'(CMD_BASE + 2 * k + 1))
                        hi_q[k] <= wr_data;
                end
            end
        end
    endgenerate

    // Software requests exist only in the write cycle
    assign sw_req = (wr_en && wr_addr == SW_ADDR) ? wr_data[NUM_SRC-1:0] : '0;

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int k = 0; k < NUM_CMD; k++) begin
            if (rd_sel == SEL_W'(k + 1)) begin
                rd_lo = lo_q[k];
                rd_hi = hi_q[k];
            end
        end
    end
endmodule

// File: rtl/pick_lowest.sv
module pick_lowest #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/adc_trig_dispatch.sv
module adc_trig_dispatch
    import adc_disp_pkg::*;
#(
    parameter  int NUM_SRC = 16,
    parameter  int NUM_CMD = 15,
    parameter  int DATA_W  = 32,
    localparam int SEL_W   = $clog2(NUM_CMD + 1),
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int ADDR_W  = $clog2(NUM_SRC + 2 * NUM_CMD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] trig_in,
    output logic               conv_valid,
    input  logic               conv_ready,
    output logic [SRC_W-1:0]   conv_src,
    output logic [SEL_W-1:0]   conv_cmd,
    output logic [DATA_W-1:0]  conv_desc_lo,
    output logic [DATA_W-1:0]  conv_desc_hi
);
    logic [NUM_SRC-1:0]            hw_rise, hw_en, sw_req;
    logic [NUM_SRC-1:0][SEL_W-1:0] sel;
    logic [NUM_SRC-1:0]            pend_q, pend_set, pend_clr;
    logic                          any_pend, grant;
    logic [SRC_W-1:0]              win_idx;
    logic [SEL_W-1:0]              win_sel;
    logic [DATA_W-1:0]             tbl_lo, tbl_hi;
    disp_state_e                   state_q, state_d;

    trig_edge_sync #(.N(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .rise    (hw_rise)
    );

    trig_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CMD (NUM_CMD),
        .SEL_W   (SEL_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sel  (win_sel),
        .hw_en   (hw_en),
        .sel     (sel),
        .sw_req  (sw_req),
        .rd_lo   (tbl_lo),
        .rd_hi   (tbl_hi)
    );

    pick_lowest #(.N(NUM_SRC), .IW(SRC_W)) u_pick (
        .req (pend_q),
        .any (any_pend),
        .idx (win_idx)
    );

    always_comb begin
        win_sel = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win_idx == SRC_W'(i)) win_sel = sel[i];
        end
    end

    // Pending requests: a new request outranks the clear of a grant
    assign pend_set = (hw_rise & hw_en) | sw_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | pend_set;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and transition controls
    always_comb begin
        state_d  = state_q;
        pend_clr = '0;
        grant    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_pend) begin
                    pend_clr[win_idx] = 1'b1;
                    if (win_sel != '0) begin
                        grant   = 1'b1;
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (conv_ready) state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs: captured at grant, held through ST_ISSUE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_src     <= '0;
            conv_cmd     <= '0;
            conv_desc_lo <= '0;
            conv_desc_hi <= '0;
        end else if (grant) begin
            conv_src     <= win_idx;
            conv_cmd     <= win_sel;
            conv_desc_lo <= tbl_lo;
            conv_desc_hi <= tbl_hi;
        end
    end

    assign conv_valid = (state_q == ST_ISSUE);
endmodule

// File: rtl/adc_trig_dispatch_chk.sv
module adc_trig_dispatch_chk #(
    parameter  int NUM_SRC = 16,
    parameter  int NUM_CMD = 15,
    parameter  int DATA_W  = 32,
    localparam int SEL_W   = $clog2(NUM_CMD + 1),
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid,
    input logic              conv_ready,
    input logic [SRC_W-1:0]  conv_src,
    input logic [SEL_W-1:0]  conv_cmd,
    input logic [DATA_W-1:0] conv_desc_lo,
    input logic [DATA_W-1:0] conv_desc_hi
);
    // R10
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && !conv_ready |=> conv_valid && $stable(conv_src) && $stable(conv_cmd)
                                      && $stable(conv_desc_lo) && $stable(conv_desc_hi));

    // R10
    gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && conv_ready |=> !conv_valid);

    // R10
    fall_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_valid) |-> $past(conv_ready));

    // R9
    no_empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |-> conv_cmd != '0);
endmodule

bind adc_trig_dispatch adc_trig_dispatch_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CMD (NUM_CMD),
    .DATA_W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_valid   (conv_valid),
    .conv_ready   (conv_ready),
    .conv_src     (conv_src),
    .conv_cmd     (conv_cmd),
    .conv_desc_lo (conv_desc_lo),
    .conv_desc_hi (conv_desc_hi)
);

// File: tb/tb_adc_trig_dispatch.sv
`timescale 1ns/1ps
module tb_adc_trig_dispatch;
    localparam int SW_ADDR = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] trig_in = '0;
    logic        conv_valid;
    logic        conv_ready = 1'b0;
    logic [3:0]  conv_src;
    logic [3:0]  conv_cmd;
    logic [31:0] conv_desc_lo, conv_desc_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    adc_trig_dispatch dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .trig_in      (trig_in),
        .conv_valid   (conv_valid),
        .conv_ready   (conv_ready),
        .conv_src     (conv_src),
        .conv_cmd     (conv_cmd),
        .conv_desc_lo (conv_desc_lo),
        .conv_desc_hi (conv_desc_hi)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_entry(input int i, input bit en, input int sel);
        wr(i, 32'((sel << 4) | int'(en)));
    endtask

    task automatic wait_valid(input int maxc, output bit got);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            if (conv_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic expect_start(input string req, input int src, input int cmd);
        bit got;
        wait_valid(20, got);
        check(got, req, longint'(got), 1);
        check(conv_src == 4'(src) && conv_cmd == 4'(cmd), req,
              {conv_src, conv_cmd}, longint'((src << 4) | cmd));
        check(conv_desc_lo == 32'hA000_0000 + 32'(cmd) && conv_desc_hi == 32'hB000_0000 + 32'(cmd),
              req, {conv_desc_hi, conv_desc_lo}, 0);
    endtask

    task automatic accept();
        conv_ready = 1'b1;
        @(negedge clk);
        conv_ready = 1'b0;
        check(!conv_valid, "R10 low after accept", longint'(conv_valid), 0);
    endtask

    task automatic expect_quiet(input string req, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (conv_valid) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, req, longint'(seen), 0);
    endtask

    task automatic t_reset();
        check(!conv_valid, "R1 valid after reset", longint'(conv_valid), 0);
        wr(SW_ADDR, 32'h0000_0001);
        expect_quiet("R1 unconfigured entry silent", 10);
    endtask

    task automatic t_load_table();
        for (int k = 1; k <= 15; k++) begin
            wr(16 + 2 * (k - 1), 32'hA000_0000 + 32'(k));
            wr(17 + 2 * (k - 1), 32'hB000_0000 + 32'(k));
        end
    endtask

    task automatic t_sw();
        set_entry(3, 1'b0, 7);
        wr(SW_ADDR, 32'h0000_0008);
        check(!conv_valid, "R4 not before second edge", longint'(conv_valid), 0);
        @(negedge clk);
        check(conv_valid, "R4 valid at second edge", longint'(conv_valid), 1);
        expect_start("R2 R3 R4 sw start", 3, 7);
        accept();
        expect_quiet("R4 self-clearing", 10);
    endtask

    task automatic t_hw();
        set_entry(6, 1'b1, 2);
        @(negedge clk);
        trig_in[6] = 1'b1;
        repeat (3) @(negedge clk);
        check(!conv_valid, "R5 not before fourth edge", longint'(conv_valid), 0);
        @(negedge clk);
        check(conv_valid, "R5 valid at fourth edge", longint'(conv_valid), 1);
        expect_start("R5 hw start", 6, 2);
        accept();
        expect_quiet("R7 held level fires once", 12);
        trig_in[6] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_hw_disabled();
        set_entry(8, 1'b0, 5);
        @(negedge clk);
        trig_in[8] = 1'b1;
        expect_quiet("R6 disabled input ignored", 12);
        trig_in[8] = 1'b0;
        repeat (4) @(negedge clk);
        wr(SW_ADDR, 32'h0000_0100);
        expect_start("R6 sw still works", 8, 5);
        accept();
    endtask

    task automatic t_prio();
        set_entry(2, 1'b0, 1);
        set_entry(5, 1'b0, 4);
        set_entry(11, 1'b0, 9);
        wr(SW_ADDR, 32'h0000_0824);
        expect_start("R8 lowest first", 2, 1);
        repeat (3) @(negedge clk);
        check(conv_valid && conv_src == 4'd2 && conv_cmd == 4'd1, "R10 held while not ready",
              {conv_valid, conv_src}, 32'h12);
        accept();
        expect_start("R8 second", 5, 4);
        accept();
        expect_start("R8 third", 11, 9);
        accept();
        expect_quiet("R8 nothing left", 8);
    endtask

    task automatic t_drop();
        set_entry(4, 1'b0, 0);
        set_entry(10, 1'b0, 3);
        wr(SW_ADDR, 32'h0000_0410);
        expect_start("R9 valid entry after drop", 10, 3);
        accept();
        expect_quiet("R9 no extra start", 8);
        wr(SW_ADDR, 32'h0000_0010);
        expect_quiet("R9 selector 0 dropped", 10);
    endtask

    task automatic t_collide();
        set_entry(1, 1'b0, 6);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(SW_ADDR); wr_data = 32'h0000_0002;
        repeat (2) @(negedge clk);
        wr_en = 1'b0;
        expect_start("R11 first", 1, 6);
        accept();
        expect_start("R11 request kept at grant", 1, 6);
        accept();
        expect_quiet("R11 no third", 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_table();
        t_sw();
        t_hw();
        t_hw_disabled();
        t_prio();
        t_drop();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule